// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches the output of a demodulated infrared receiver and records the raw timing of an incoming remote-control burst. The active-low input is synchronised and de-glitched. Each mark and each space is then measured as an 8-bit count of sample ticks, and the counts are packed into a bank of seventeen 32-bit capture words. The sample tick comes from a programmable divider of the block clock. Mark is input logic 0.

A burst ends in one of two ways. A space that reaches 255 ticks is stored as 0xFF and ends the message. Otherwise, when all 68 width slots have been filled, the remaining edges are dropped. After that, once the line has stayed idle for a programmable number of ticks, the block sets a pending flag and can raise an interrupt. Capture then stays frozen until software writes the restart control, which empties the bank and re-arms the receiver. Software reads the widths and decodes the protocol.

The only data path is the register port. Writes take effect at the clock edge where the write strobe is high. Read data is registered and appears one cycle after the read strobe. The port is always ready and has no back-pressure, so no valid/ready handshake is used.

Top module: `irrx_width_capture`

## Requirements
- R1: After reset every capture word reads 0, irq_o is 0, and the pending bit reads 0. The config word at address 0x00 reads 0x000F0000 (idle limit 15). The divider at address 0x01 reads 1, and the filter word at address 0x02 reads 0x100 (need count 1).
- R2: After a restart, the first stored width is a mark (rx_n_i low) and later slots alternate space, mark, space. Slot k sits in capture word k/4 at bits 8*(k%4)+7 : 8*(k%4), so the earliest width is in bits 7:0.
- R3: A sample tick occurs once every max(D,1) clock cycles, where D is bits 15:0 of address 0x01. A level held for N ticks and then ended by an accepted change is stored as N, up to 255.
- R4: A space that lasts 255 ticks stores 0xFF in the next slot and ends the message.
- R5: Once all 68 slots are filled, further edges are ignored. Completion still follows once the line has been idle long enough.
- R6: After a message ends, the pending bit (address 0x06 bit 0) is set once L consecutive idle ticks have passed, where L is config bits 23:16. irq_o equals pending AND interrupt enable (address 0x04 bit 0).
- R7: Writing 1 to bit 0 of address 0x05 clears the pending bit and drops irq_o.
- R8: Writing 1 to bit 0 of address 0x03 returns capture to idle and zeroes all 17 capture words.
- R9: An input change is accepted only after G consecutive ticks at the new level, where G is bits 12:8 of address 0x02 (0 acts as 1). Shorter pulses are absorbed into the surrounding width.
- R10: Capture runs only while config bit 0 (receiver on) and bit 13 (width measurement on) are both 1. Otherwise input activity changes no capture word and sets no pending bit.
- R11: After completion, input activity leaves the capture words unchanged until a restart, even after the pending bit is cleared.
- R12: A read strobe returns data on reg_rdata_o in the next cycle. Capture word i is at address 0x20+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_n_i | input | 1 | Demodulated receiver line, low = mark |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after reg_rd_i |
| irq_o | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the ports is a full bank, where all 68 slots are taken and the receiver is in its ignore-and-wait phase. The bench reaches it with a burst of 71 short random widths, driven at tick-aligned instants so that every stored count is exact. It then checks that only the first 68 widths are stored. Glitch rejection is reached by raising the need count and inserting pulses one or two ticks shorter than that count. The expected result is that these pulses merge into the neighbouring widths.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_WAIT = 2'd2,
    CAP_DONE = 2'd3
  } cap_state_e;

  // register word addresses
  localparam int unsigned REG_CFG     = 'h00;
  localparam int unsigned REG_DIV     = 'h01;
  localparam int unsigned REG_FILT    = 'h02;
  localparam int unsigned REG_RESTART = 'h03;
  localparam int unsigned REG_IEN     = 'h04;
  localparam int unsigned REG_ACK     = 'h05;
  localparam int unsigned REG_STAT    = 'h06;
  localparam int unsigned REG_CAP     = 'h20;

  // field positions
  localparam int unsigned CFG_RX_BIT   = 0;
  localparam int unsigned CFG_PW_BIT   = 13;
  localparam int unsigned CFG_IDLE_LSB = 16;
  localparam int unsigned FILT_LSB     = 8;
endpackage

// File: rtl/irrx_tick_gen.sv
module irrx_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] period_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last   = (period_i == '0) ? '0 : period_i - 1'b1;
  assign tick_o = run_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irrx_line_filter.sv
module irrx_line_filter #(
  parameter int unsigned DG_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_n_i,
  input  logic            tick_i,
  input  logic [DG_W-1:0] need_i,
  output logic            mark_o
);
  logic           s1_q, s2_q;
  logic           raw_mark;
  logic           lvl_q;
  logic [DG_W:0]  run_q;
  logic [DG_W:0]  need_eff;

  assign raw_mark = ~s2_q;
  assign need_eff = (need_i == '0) ? (DG_W+1)'(1) : {1'b0, need_i};
  assign mark_o   = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx_n_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (tick_i) begin
      if (raw_mark != lvl_q) begin
        if (run_q + 1'b1 >= need_eff) begin
          lvl_q <= raw_mark;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/irrx_capture_bank.sv
module irrx_capture_bank
  import irrx_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 17,
  parameter int unsigned W_BITS    = 8,
  parameter int unsigned PER_WORD  = 4,
  localparam int unsigned SLOTS    = NUM_WORDS * PER_WORD,
  localparam int unsigned SLOT_W   = $clog2(SLOTS + 1),
  localparam int unsigned WORD_W   = W_BITS * PER_WORD
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              tick_i,
  input  logic                              mark_i,
  input  logic                              restart_i,
  input  logic [W_BITS-1:0]                 idle_lim_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  words_o,
  output cap_state_e                        state_o,
  output logic [SLOT_W-1:0]                 slot_o,
  output logic                              done_o
);
  localparam int unsigned SLOT_IW = $clog2(SLOTS);
  localparam logic [W_BITS-1:0] WMAX = '1;

  logic [SLOTS-1:0][W_BITS-1:0] slot_q;
  cap_state_e                   state_q;
  logic [SLOT_W-1:0]            idx_q;
  logic [W_BITS-1:0]            wcnt_q;
  logic [W_BITS-1:0]            icnt_q;
  logic                         cur_q;
  logic                         last_slot;

  assign last_slot = (idx_q == SLOT_W'(SLOTS - 1));
  assign done_o    = (state_q == CAP_WAIT) && (icnt_q >= idle_lim_i) && !restart_i;
  assign state_o   = state_q;
  assign slot_o    = idx_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words_o[w] = slot_q[w*PER_WORD +: PER_WORD];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      state_q <= CAP_IDLE;
      idx_q   <= '0;
      wcnt_q  <= '0;
      icnt_q  <= '0;
      cur_q   <= 1'b0;
    end else if (restart_i) begin
      slot_q  <= '0;
      state_q <= CAP_IDLE;
      idx_q   <= '0;
      wcnt_q  <= '0;
      icnt_q  <= '0;
      cur_q   <= 1'b0;
    end else begin
      if (tick_i) begin
        case (state_q)
          CAP_IDLE: begin
            if (mark_i) begin
              state_q <= CAP_RUN;
              cur_q   <= 1'b1;
              wcnt_q  <= W_BITS'(1);
            end
          end
          CAP_RUN: begin
            if (mark_i != cur_q) begin
              slot_q[idx_q[SLOT_IW-1:0]] <= wcnt_q;
              idx_q  <= idx_q + 1'b1;
              cur_q  <= mark_i;
              wcnt_q <= W_BITS'(1);
              if (last_slot) begin
                state_q <= CAP_WAIT;
                icnt_q  <= '0;
              end
            end else if (!cur_q && wcnt_q == WMAX - 1'b1) begin
              slot_q[idx_q[SLOT_IW-1:0]] <= WMAX;
              idx_q   <= idx_q + 1'b1;
              state_q <= CAP_WAIT;
              icnt_q  <= '0;
            end else if (wcnt_q != WMAX) begin
              wcnt_q <= wcnt_q + 1'b1;
            end
          end
          CAP_WAIT: begin
            if (mark_i)              icnt_q <= '0;
            else if (icnt_q != WMAX) icnt_q <= icnt_q + 1'b1;
          end
          default: ;
        endcase
      end
      if (done_o) state_q <= CAP_DONE;
    end
  end
endmodule

// File: rtl/irrx_width_capture.sv
module irrx_width_capture
  import irrx_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 17,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DG_W      = 5,
  parameter int unsigned W_BITS    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_n_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned PER_WORD = DATA_W / W_BITS;
  localparam int unsigned SLOTS    = NUM_WORDS * PER_WORD;
  localparam int unsigned SLOT_W   = $clog2(SLOTS + 1);
  localparam int unsigned WIDX_W   = $clog2(NUM_WORDS);
  localparam logic [ADDR_W-1:0] CAP_LO = ADDR_W'(REG_CAP);
  localparam logic [ADDR_W-1:0] CAP_HI = ADDR_W'(REG_CAP + NUM_WORDS);

  logic              rx_on_q, width_on_q, int_en_q, pend_q;
  logic [W_BITS-1:0] idle_lim_q;
  logic [DIV_W-1:0]  div_q;
  logic [DG_W-1:0]   need_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  logic              cap_active, cap_tick, cap_mark, cap_done;
  logic              restart_pulse, ack_pulse;
  cap_state_e        cap_state;
  logic [SLOT_W-1:0] cap_slot;
  logic [NUM_WORDS-1:0][DATA_W-1:0] cap_words;
  logic              word_hit;
  logic [ADDR_W-1:0] word_off;

  assign cap_active    = rx_on_q && width_on_q;
  assign restart_pulse = reg_wr_i && (reg_addr_i == ADDR_W'(REG_RESTART)) && reg_wdata_i[0];
  assign ack_pulse     = reg_wr_i && (reg_addr_i == ADDR_W'(REG_ACK)) && reg_wdata_i[0];
  assign irq_o         = pend_q && int_en_q;
  assign reg_rdata_o   = rdata_q;

  irrx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(cap_active), .period_i(div_q), .tick_o(cap_tick)
  );

  irrx_line_filter #(.DG_W(DG_W)) u_filt (
    .clk_i, .rst_ni, .rx_n_i, .tick_i(cap_tick), .need_i(need_q), .mark_o(cap_mark)
  );

  irrx_capture_bank #(.NUM_WORDS(NUM_WORDS), .W_BITS(W_BITS), .PER_WORD(PER_WORD)) u_bank (
    .clk_i, .rst_ni, .tick_i(cap_tick), .mark_i(cap_mark), .restart_i(restart_pulse),
    .idle_lim_i(idle_lim_q), .words_o(cap_words), .state_o(cap_state),
    .slot_o(cap_slot), .done_o(cap_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_on_q    <= 1'b0;
      width_on_q <= 1'b0;
      idle_lim_q <= W_BITS'(15);
      div_q      <= DIV_W'(1);
      need_q     <= DG_W'(1);
      int_en_q   <= 1'b0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        ADDR_W'(REG_CFG): begin
          rx_on_q    <= reg_wdata_i[CFG_RX_BIT];
          width_on_q <= reg_wdata_i[CFG_PW_BIT];
          idle_lim_q <= reg_wdata_i[CFG_IDLE_LSB +: W_BITS];
        end
        ADDR_W'(REG_DIV):  div_q    <= reg_wdata_i[DIV_W-1:0];
        ADDR_W'(REG_FILT): need_q   <= reg_wdata_i[FILT_LSB +: DG_W];
        ADDR_W'(REG_IEN):  int_en_q <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (cap_done)  pend_q <= 1'b1;
    else if (ack_pulse) pend_q <= 1'b0;
  end

  assign word_hit = (reg_addr_i >= CAP_LO) && (reg_addr_i < CAP_HI);
  assign word_off = reg_addr_i - CAP_LO;

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      ADDR_W'(REG_CFG): begin
        rd_mux[CFG_RX_BIT]                = rx_on_q;
        rd_mux[CFG_PW_BIT]                = width_on_q;
        rd_mux[CFG_IDLE_LSB +: W_BITS]    = idle_lim_q;
      end
      ADDR_W'(REG_DIV):  rd_mux[DIV_W-1:0]        = div_q;
      ADDR_W'(REG_FILT): rd_mux[FILT_LSB +: DG_W] = need_q;
      ADDR_W'(REG_IEN):  rd_mux[0]                = int_en_q;
      ADDR_W'(REG_STAT): rd_mux[0]                = pend_q;
      default: if (word_hit) rd_mux = cap_words[word_off[WIDX_W-1:0]];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end
endmodule

// File: rtl/irrx_width_capture_chk.sv
module irrx_width_capture_chk
  import irrx_pkg::*;
#(
  parameter int unsigned SLOT_W = 7,
  parameter int unsigned SLOTS  = 68
) (
  input logic              clk_i,
  input logic              rst_ni,
  input cap_state_e        state_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic              pend_i,
  input logic              active_i,
  input logic              tick_i,
  input logic              restart_i,
  input logic              ack_i,
  input logic              done_i
);
  // R8
  restart_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_i == CAP_IDLE && slot_i == '0));

  // R6
  pend_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_i) |-> $past(state_i) == CAP_WAIT);

  // R5
  slot_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i <= SLOT_W'(SLOTS));

  // R11
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == CAP_DONE && !restart_i) |=> (state_i == CAP_DONE && $stable(slot_i)));

  // R10
  idle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !tick_i);

  // R10
  frozen_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !restart_i) |=> $stable(slot_i));

  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !done_i) |=> !pend_i);
endmodule

bind irrx_width_capture irrx_width_capture_chk #(.SLOT_W(SLOT_W), .SLOTS(SLOTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(cap_state), .slot_i(cap_slot),
  .pend_i(pend_q), .active_i(cap_active), .tick_i(cap_tick),
  .restart_i(restart_pulse), .ack_i(ack_pulse), .done_i(cap_done)
);

// File: tb/irrx_width_capture_tb.sv
`timescale 1ns/1ps
module irrx_width_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_n = 1'b1;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  irrx_width_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_n_i(rx_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int P = 1;
  int exp_w[68];
  int exp_n = 0;
  int msg_w[80];
  logic [31:0] full_cfg;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); d = rdata; rd = 1'b0;
  endtask

  task automatic drive(input bit mark, input int ticks);
    rx_n = mark ? 1'b0 : 1'b1;
    repeat (ticks * P) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    wr_reg(6'h01, 32'(d));
    P = (d == 0) ? 1 : d;
  endtask

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      if (w*4 + k < exp_n) r[k*8 +: 8] = 8'(exp_w[w*4 + k]);
    end
    return r;
  endfunction

  task automatic check_words(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 17; i++) begin
      rd_reg(6'(32 + i), v);
      chk(tag, v, exp_word(i), $sformatf("capture word %0d", i));
    end
  endtask

  task automatic wait_irq(input string tag, input int limit);
    int t = 0;
    while (irq !== 1'b1 && t < limit) begin @(negedge clk); t++; end
    chk(tag, {31'd0, irq}, 32'd1, "irq after idle timeout");
  endtask

  task automatic send_msg(input int n);
    for (int i = 0; i < n; i++) drive((i % 2) == 0, msg_w[i]);
    rx_n = 1'b1;
  endtask

  task automatic clean_up();
    wr_reg(6'h05, 32'd1);
    wr_reg(6'h03, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4417));
    full_cfg = (32'd15 << 16) | (32'd1 << 13) | 32'd1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    exp_n = 0;
    check_words("R1");
    rd_reg(6'h00, v); chk("R1", v, 32'h000F0000, "config reset");
    rd_reg(6'h01, v); chk("R1", v, 32'd1, "divider reset");
    rd_reg(6'h02, v); chk("R1", v, 32'h100, "filter reset");
    rd_reg(6'h06, v); chk("R1", v, 32'd0, "pending reset");
    chk("R1", {31'd0, irq}, 32'd0, "irq reset");

    // R2 R3 R4 R6 R12: directed message with timing window on completion
    set_div(4);
    wr_reg(6'h04, 32'd1);
    wr_reg(6'h00, full_cfg);
    msg_w[0] = 9; msg_w[1] = 4; msg_w[2] = 3; msg_w[3] = 7; msg_w[4] = 12;
    send_msg(5);
    repeat (268 * P) @(negedge clk);
    chk("R6", {31'd0, irq}, 32'd0, "irq not before idle limit");
    wait_irq("R6", 10 * P);
    for (int i = 0; i < 5; i++) exp_w[i] = msg_w[i];
    exp_w[5] = 255; exp_n = 6;
    check_words("R2");
    rd_reg(6'h06, v); chk("R6", v, 32'd1, "pending after completion");

    // R11 frozen after completion
    drive(1'b1, 6); drive(1'b0, 6); drive(1'b1, 6); rx_n = 1'b1;
    repeat (300 * P) @(negedge clk);
    check_words("R11");
    // R6 enable gates the interrupt line
    wr_reg(6'h04, 32'd0);
    chk("R6", {31'd0, irq}, 32'd0, "irq masked");
    rd_reg(6'h06, v); chk("R6", v, 32'd1, "pending while masked");
    wr_reg(6'h04, 32'd1);
    chk("R6", {31'd0, irq}, 32'd1, "irq unmasked");
    // R7 acknowledge
    wr_reg(6'h05, 32'd1);
    chk("R7", {31'd0, irq}, 32'd0, "irq after ack");
    rd_reg(6'h06, v); chk("R7", v, 32'd0, "pending after ack");
    drive(1'b1, 5); rx_n = 1'b1;
    repeat (300 * P) @(negedge clk);
    check_words("R11");
    // R8 restart zeroes the bank
    wr_reg(6'h03, 32'd1);
    exp_n = 0;
    check_words("R8");

    // R2 R3 R4: random messages at several tick periods
    for (int r = 0; r < 3; r++) begin
      int n;
      set_div(r == 0 ? 0 : 3 * r);
      n = 2 * int'($urandom_range(12, 1)) + 1;
      for (int i = 0; i < n; i++) msg_w[i] = int'($urandom_range(100, 1));
      send_msg(n);
      wait_irq("R4", 300 * P);
      for (int i = 0; i < n; i++) exp_w[i] = msg_w[i];
      exp_w[n] = 255; exp_n = n + 1;
      check_words("R3");
      clean_up();
    end

    // R5 bank overflow
    set_div(2);
    for (int i = 0; i < 71; i++) msg_w[i] = int'($urandom_range(6, 2));
    send_msg(71);
    wait_irq("R5", 300 * P);
    for (int i = 0; i < 68; i++) exp_w[i] = msg_w[i];
    exp_n = 68;
    check_words("R5");
    clean_up();

    // R9 glitch rejection with need count 3
    set_div(4);
    wr_reg(6'h02, 32'd3 << 8);
    drive(1'b1, 6); drive(1'b0, 1); drive(1'b1, 5);
    drive(1'b0, 8); drive(1'b1, 2); drive(1'b0, 7);
    drive(1'b1, 10); rx_n = 1'b1;
    wait_irq("R9", 300 * P);
    exp_w[0] = 12; exp_w[1] = 17; exp_w[2] = 10; exp_w[3] = 255; exp_n = 4;
    check_words("R9");
    clean_up();
    wr_reg(6'h02, 32'd1 << 8);

    // R10 capture needs both enable bits
    wr_reg(6'h00, (32'd15 << 16) | 32'd1);
    drive(1'b1, 5); drive(1'b0, 5); drive(1'b1, 5); rx_n = 1'b1;
    repeat (300 * P) @(negedge clk);
    exp_n = 0;
    check_words("R10");
    rd_reg(6'h06, v); chk("R10", v, 32'd0, "no pending with width off");
    wr_reg(6'h00, (32'd15 << 16) | (32'd1 << 13));
    drive(1'b1, 5); drive(1'b0, 5); drive(1'b1, 5); rx_n = 1'b1;
    repeat (300 * P) @(negedge clk);
    rd_reg(6'h20, v); chk("R10", v, 32'd0, "word 0 with receiver off");
    rd_reg(6'h06, v); chk("R10", v, 32'd0, "no pending with receiver off");
    wr_reg(6'h00, full_cfg);
    msg_w[0] = 20;
    send_msg(1);
    wait_irq("R10", 300 * P);
    exp_w[0] = 20; exp_w[1] = 255; exp_n = 2;
    check_words("R12");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule